// File: doc/BRIEF.md
# Drowsy Line Manager for an Instruction Cache

This block decides, line by line, which instruction-cache lines are held at full supply and which are left in the low-leakage retention state. It also decides which sub-banks have their bitlines precharged. It watches the fetch stream and nothing else. Each fetch marks its line as used and wakes that line and the line that follows it, so straight-line code rarely meets a sleeping line. A long fixed window runs in the background. When the window closes, every line that saw no fetch during it is dropped to the retention state, and the usage history starts again from empty.

Bitline precharge is kept per sub-bank. The sub-bank that holds the current fetch stays precharged. When fetch moves to another sub-bank, the one it left keeps its precharge for a short linger period and is then isolated. The stall output tells the fetch unit that the fetch now being presented costs one extra cycle. That happens when the line is asleep, when its sub-bank is isolated, or when both are true at once.

Top module: `drowsy_line_mgr`

## Requirements
- R1: After reset every line is active, every sub-bank is isolated (precharge low), the usage history is empty and stall is low.
- R2: A window ends on the 32768th clock edge after reset and on every 32768th edge after that. At that edge, every line not fetched during the window leaves the active state. Lines fetched during the window stay active.
- R3: The usage history is cleared at each window end. A line fetched in one window but not in the next goes to the retention state at the end of the next window.
- R4: A fetch of line L makes line L and line (L+1) modulo 1024 active from the following cycle. A fetch of line 1023 therefore wakes line 0.
- R5: The sub-bank of line L is bits [9:7] of L. A fetch makes its sub-bank precharged from the next cycle, and it stays precharged while it is the current sub-bank.
- R6: When fetch moves to a different sub-bank, the sub-bank it left stays precharged for exactly 16 further cycles and is then isolated. A fetch back into a lingering sub-bank cancels its countdown.
- R7: Stall is high in a cycle with a fetch if and only if the target line is not active or its sub-bank is not precharged.
- R8: A sleeping line in an isolated sub-bank stalls for only one cycle. Presenting the same fetch again in the next cycle does not stall.
- R9: Stall is low in every cycle without a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchLine | input | 10 | Line index of the fetch |
| lineActive | output | 1024 | Per-line active flag, 1 = full supply |
| bankPrecharge | output | 8 | Per-sub-bank bitline precharge enable |
| stall | output | 1 | The current fetch costs one extra cycle |

## Verification
Two penalties can fall in the same cycle: the line-wakeup penalty and the sub-bank precharge penalty. The bench provokes this by fetching, after a window end, a line that is now asleep and that sits in a sub-bank that has never been precharged. It then presents the same fetch again in the next cycle. The result is judged correct only if stall is high in the first cycle and low in the second, which shows that both penalties were absorbed in one cycle. A sleeping line inside an already precharged sub-bank is also fetched, to show that the wakeup penalty alone still raises stall.

// File: rtl/drowsy_pkg.sv
`timescale 1ns/1ps
package drowsy_pkg;
  localparam int NUM_LINES      = 1024;
  localparam int NUM_BANKS      = 8;
  localparam int WINDOW_CYCLES  = 32768;
  localparam int HOLD_CYCLES    = 16;
  localparam int LINE_W         = $clog2(NUM_LINES);
  localparam int BANK_W         = $clog2(NUM_BANKS);
  localparam int LINES_PER_BANK = NUM_LINES / NUM_BANKS;
  localparam int BANK_SHIFT     = $clog2(LINES_PER_BANK);
  localparam int WIN_W          = $clog2(WINDOW_CYCLES);
  localparam int HOLD_W         = $clog2(HOLD_CYCLES + 1);

  typedef struct packed {
    logic              touch;
    logic              windowEnd;
    logic [LINE_W-1:0] hitLine;
    logic [LINE_W-1:0] nextLine;
  } lineStrobe_t;
endpackage

// File: rtl/drowsy_ctrl.sv
`timescale 1ns/1ps
module drowsy_ctrl
  import drowsy_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetchValid,
  input  logic [LINE_W-1:0]    fetchLine,
  output lineStrobe_t          strobe,
  output logic [NUM_BANKS-1:0] bankPrecharge
);
  logic [WIN_W-1:0]  winCnt;
  logic              windowEnd;
  logic [BANK_W-1:0] fetchBank;
  logic [BANK_W-1:0] curBank;
  logic              curValid;
  logic              leaving;
  logic [HOLD_W-1:0] holdCnt [NUM_BANKS];

  assign windowEnd = (winCnt == WIN_W'(WINDOW_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         winCnt <= '0;
    else if (windowEnd) winCnt <= '0;
    else                winCnt <= winCnt + 1'b1;
  end

  assign fetchBank = BANK_W'(fetchLine >> BANK_SHIFT);
  assign leaving   = fetchValid && curValid && (fetchBank != curBank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curBank  <= '0;
      curValid <= 1'b0;
    end else if (fetchValid) begin
      curBank  <= fetchBank;
      curValid <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        holdCnt[b] <= '0;
      else if (fetchValid && fetchBank == BANK_W'(b))
        holdCnt[b] <= '0;
      else if (leaving && curBank == BANK_W'(b))
        holdCnt[b] <= HOLD_W'(HOLD_CYCLES);
      else if (holdCnt[b] != '0)
        holdCnt[b] <= holdCnt[b] - 1'b1;
    end
    assign bankPrecharge[b] = (curValid && curBank == BANK_W'(b)) || (holdCnt[b] != '0);
  end

  always_comb begin
    strobe.touch     = fetchValid;
    strobe.windowEnd = windowEnd;
    strobe.hitLine   = fetchLine;
    strobe.nextLine  = (fetchLine == LINE_W'(NUM_LINES - 1)) ? '0 : fetchLine + 1'b1;
  end
endmodule

// File: rtl/drowsy_lines.sv
`timescale 1ns/1ps
module drowsy_lines
  import drowsy_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  lineStrobe_t          strobe,
  output logic [NUM_LINES-1:0] lineActive
);
  logic [NUM_LINES-1:0] accessed;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit, wake;
    assign hit  = strobe.touch && (strobe.hitLine == LINE_W'(i));
    assign wake = hit || (strobe.touch && strobe.nextLine == LINE_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lineActive[i] <= 1'b1;
        accessed[i]   <= 1'b0;
      end else if (strobe.windowEnd) begin
        lineActive[i] <= (lineActive[i] && (accessed[i] || hit)) || wake;
        accessed[i]   <= 1'b0;
      end else begin
        if (wake) lineActive[i] <= 1'b1;
        if (hit)  accessed[i]   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/drowsy_line_mgr.sv
`timescale 1ns/1ps
module drowsy_line_mgr
  import drowsy_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetchValid,
  input  logic [LINE_W-1:0]    fetchLine,
  output logic [NUM_LINES-1:0] lineActive,
  output logic [NUM_BANKS-1:0] bankPrecharge,
  output logic                 stall
);
  lineStrobe_t       strobe;
  logic [BANK_W-1:0] reqBank;

  drowsy_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchLine(fetchLine),
    .strobe(strobe), .bankPrecharge(bankPrecharge)
  );

  drowsy_lines u_lines (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lineActive(lineActive)
  );

  assign reqBank = BANK_W'(fetchLine >> BANK_SHIFT);
  assign stall   = fetchValid && (!lineActive[fetchLine] || !bankPrecharge[reqBank]);
endmodule

// File: rtl/drowsy_mgr_chk.sv
`timescale 1ns/1ps
module drowsy_mgr_chk
  import drowsy_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetchValid,
  input logic [LINE_W-1:0]    fetchLine,
  input logic [NUM_LINES-1:0] lineActive,
  input logic [NUM_BANKS-1:0] bankPrecharge,
  input logic                 stall
);
  // R4
  fetched_line_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid |=> lineActive[$past(fetchLine)]);

  // R5
  fetched_bank_precharged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid |=> bankPrecharge[BANK_W'($past(fetchLine) >> BANK_SHIFT)]);

  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && stall) |=> !(fetchValid && $stable(fetchLine) && stall));

  // R9
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchValid |-> !stall);
endmodule

bind drowsy_line_mgr drowsy_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchLine(fetchLine),
  .lineActive(lineActive), .bankPrecharge(bankPrecharge), .stall(stall)
);

// File: tb/test_drowsy_line_mgr.sv
`timescale 1ns/1ps
module test_drowsy_line_mgr;
  localparam int WIN = 32768;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetchValid = 1'b0;
  logic [9:0]   fetchLine = '0;
  logic [1023:0] lineActive;
  logic [7:0]   bankPrecharge;
  logic         stall;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) edgeCnt <= edgeCnt + 1;

  drowsy_line_mgr i_drowsy_line_mgr (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchLine(fetchLine),
    .lineActive(lineActive), .bankPrecharge(bankPrecharge), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // presents one fetch for one cycle, returns stall seen in that cycle
  task automatic doFetch(input int line, output bit st);
    fetchValid = 1'b1;
    fetchLine  = 10'(line);
    #1 st = stall;
    tick();
    fetchValid = 1'b0;
  endtask

  task automatic waitWindow(input int line, input int expEdge, input string req);
    int guard = 0;
    while (lineActive[line] && guard < WIN + 10) begin tick(); guard++; end
    chk(edgeCnt == expEdge, req, edgeCnt, expEdge);
  endtask

  task automatic testReset();
    chk(&lineActive, "R1", int'($countones(lineActive)), 1024);
    chk(bankPrecharge == 8'h00, "R1", int'(bankPrecharge), 0);
    chk(stall == 1'b0, "R1", int'(stall), 0);
  endtask

  task automatic testFirstFetch();
    bit st;
    doFetch(5, st);
    chk(st == 1'b1, "R7 isolated bank stalls", int'(st), 1);
    chk(bankPrecharge == 8'h01, "R5 bank 0 precharged", int'(bankPrecharge), 1);
    doFetch(5, st);
    chk(st == 1'b0, "R7 active line in live bank", int'(st), 0);
  endtask

  task automatic testWindowOne();
    waitWindow(700, WIN, "R2 window end edge");
    chk(lineActive[5] == 1'b1, "R2 fetched line stays", int'(lineActive[5]), 1);
    chk(lineActive[6] == 1'b0, "R2 unfetched line sleeps", int'(lineActive[6]), 0);
    chk(lineActive[0] == 1'b0, "R2 line 0 sleeps", int'(lineActive[0]), 0);
    fetchLine = 10'd10; #1;
    chk(stall == 1'b0, "R9 no fetch no stall", int'(stall), 0);
  endtask

  task automatic testNextLine();
    bit st;
    doFetch(10, st);
    chk(st == 1'b1, "R7 drowsy line stalls", int'(st), 1);
    chk(lineActive[10] && lineActive[11], "R4 line and successor awake",
        int'({lineActive[10], lineActive[11]}), 3);
    doFetch(11, st);
    chk(st == 1'b0, "R4 successor fetched without stall", int'(st), 0);
    doFetch(1023, st);
    chk(lineActive[0] == 1'b1, "R4 wrap 1023 to 0", int'(lineActive[0]), 1);
  endtask

  task automatic testBankHold();
    bit st;
    doFetch(20, st);
    doFetch(130, st);
    chk(bankPrecharge[1] == 1'b1, "R5 new bank on", int'(bankPrecharge[1]), 1);
    for (int n = 0; n < 16; n++) begin
      chk(bankPrecharge[0] == 1'b1, "R6 left bank lingers", int'(bankPrecharge[0]), 1);
      tick();
    end
    chk(bankPrecharge[0] == 1'b0, "R6 left bank isolated", int'(bankPrecharge[0]), 0);
    doFetch(131, st);
    doFetch(21, st);
    tick(); tick();
    doFetch(132, st);
    chk(st == 1'b0, "R6 return to lingering bank", int'(st), 0);
    for (int n = 0; n < 20; n++) tick();
    chk(bankPrecharge == 8'h02, "R6 countdown cancelled then expired", int'(bankPrecharge), 2);
  endtask

  task automatic testOverlap();
    bit st;
    fetchValid = 1'b1;
    fetchLine  = 10'd650;
    #1 st = stall;
    chk(st == 1'b1, "R8 double penalty stalls", int'(st), 1);
    tick();
    #1 st = stall;
    chk(st == 1'b0, "R8 stall lasts one cycle", int'(st), 0);
    tick();
    fetchValid = 1'b0;
  endtask

  task automatic testWindowTwo();
    waitWindow(5, 2 * WIN, "R3 second window end edge");
    chk(lineActive[5] == 1'b0, "R3 history cleared", int'(lineActive[5]), 0);
    chk(lineActive[10] == 1'b1, "R3 refetched line stays", int'(lineActive[10]), 1);
  endtask

  initial begin
    #1;
    repeat (3) tick();
    testReset();
    rst_n = 1'b1;
    testFirstFetch();
    testWindowOne();
    testNextLine();
    testBankHold();
    testOverlap();
    testWindowTwo();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2: actual %0d expected %0d", edgeCnt, 2 * WIN);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule